// File: doc/BRIEF.md
# Wrapping Multiply-Accumulate with Rollover Pulse

This block multiplies two operands of a configurable user width and adds the product into an accumulator that wraps modulo 2^ACC_W on every cycle where the valid strobe is high. The operands are first placed in the smallest native multiplier width (9, 18 or 36 bits) that holds them. In unsigned mode the unused upper bits are filled with zeros. In signed mode the operand is treated as two's complement and its top bit is copied upward.

The accumulator never saturates. When an addition rolls the accumulator over, the block raises a registered overflow pulse for exactly one cycle. In unsigned mode a rollover is a carry out of the top bit. In signed mode it is two same-signed values giving a sum of the opposite sign. An up/down counter of these pulses supplies the upper word of a wider result, so the true running total is ext_cnt * 2^ACC_W + acc_out. In signed mode acc_out is read as two's complement for this sum.

A synchronous clear zeroes the whole state. The mode input is sampled on each cycle, so signed and unsigned updates can be mixed.

Top module: `mac_top`

## Requirements
- R1: In unsigned mode (is_signed=0), each operand is zero-extended to the native width. The value added on a valid cycle is (op_a * op_b) mod 2^ACC_W, with both operands read as unsigned.
- R2: In signed mode (is_signed=1), each operand is sign-extended from bit OP_W-1. The value added is (op_a * op_b) mod 2^ACC_W, with both operands read as two's complement (for example, 4-bit 1010 counts as -6).
- R3: On each cycle with valid=1 and clear=0, acc_out becomes (previous acc_out + addend) mod 2^ACC_W after the next rising clock edge. The value wraps rather than saturating.
- R4: In unsigned mode, ovf_pulse is 1 after an update exactly when previous acc_out + addend >= 2^ACC_W.
- R5: In signed mode, ovf_pulse is 1 after an update exactly when the old accumulator and the addend have the same top bit (bit ACC_W-1) and the wrapped sum's top bit differs from it.
- R6: ovf_pulse is registered and first appears in the same cycle as the wrapped accumulator value. It lasts one cycle unless the next update overflows as well.
- R7: When valid=0 and clear=0, acc_out and ext_cnt hold their values and ovf_pulse is 0.
- R8: After rst_n is low, or after a cycle with clear=1, acc_out, ext_cnt and ovf_pulse are all 0.
- R9: ext_cnt (modulo 2^EXT_W) changes on a rollover. It increments on an unsigned carry or a signed positive overflow (top bits 0,0 giving 1). It decrements on a signed negative overflow (top bits 1,1 giving 0). Otherwise it is unchanged.
- R10: clear takes priority over valid. A cycle with both high leaves all state at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all state |
| valid | input | 1 | Accumulate this cycle's product |
| is_signed | input | 1 | 1 = two's complement operands and rules, 0 = unsigned |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| acc_out | output | ACC_W | Wrapped accumulator value |
| ovf_pulse | output | 1 | One-cycle rollover indication |
| ext_cnt | output | EXT_W | Up/down count of rollovers, the upper word of the extended total |

## Verification
The bench builds the block with OP_W=4, which selects the 9-bit native width, together with ACC_W=10 and EXT_W=6. With only 16 values per operand, every operand pair can be swept in both modes, and every sign-extension case is covered. A 10-bit accumulator rolls over within a handful of large products, so carries, positive and negative signed overflows, back-to-back pulses and counter decrements all occur many times in a short run. Directed runs then pin down specific crossings, the clear-over-valid priority and idle holds.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Smallest native multiplier width that holds a user operand.
  function automatic int native_width(input int user_w);
    if (user_w <= 9)       return 9;
    else if (user_w <= 18) return 18;
    else                   return 36;
  endfunction

  typedef enum logic [1:0] {
    ROLL_NONE = 2'd0,
    ROLL_UP   = 2'd1,
    ROLL_DOWN = 2'd2
  } roll_dir_e;

endpackage

// File: rtl/mac_operand_map.sv
module mac_operand_map #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 9
) (
  input  logic             is_signed,
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] mapped
);
  generate
    if (OUT_W > IN_W) begin : g_widen
      localparam int FILL_W = OUT_W - IN_W;
      logic fill_bit;
      assign fill_bit = is_signed & raw[IN_W-1];
      assign mapped   = {{FILL_W{fill_bit}}, raw};
    end else begin : g_pass
      logic unused_mode;
      assign unused_mode = is_signed;
      assign mapped      = raw[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int NW    = 9,
  parameter int ACC_W = 18
) (
  input  logic             is_signed,
  input  logic [NW-1:0]    a_n,
  input  logic [NW-1:0]    b_n,
  output logic [ACC_W-1:0] addend
);
  // The low ACC_W bits of a product depend only on the low ACC_W bits of
  // the operands, so the multiply is done at accumulator width.
  logic [ACC_W-1:0] a_w, b_w;

  generate
    if (ACC_W > NW) begin : g_grow
      localparam int PAD_W = ACC_W - NW;
      assign a_w = {{PAD_W{is_signed & a_n[NW-1]}}, a_n};
      assign b_w = {{PAD_W{is_signed & b_n[NW-1]}}, b_n};
    end else begin : g_cut
      assign a_w = a_n[ACC_W-1:0];
      assign b_w = b_n[ACC_W-1:0];
    end
  endgenerate

  assign addend = a_w * b_w;
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             valid,
  input  logic             is_signed,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc,
  output logic             ovf_pulse,
  output logic             carry_evt,
  output logic             pos_evt,
  output logic             neg_evt
);
  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] acc_next;
  logic             top_a, top_b, top_s;

  assign sum_w    = {1'b0, acc} + {1'b0, addend};
  assign acc_next = sum_w[ACC_W-1:0];
  assign top_a    = acc[ACC_W-1];
  assign top_b    = addend[ACC_W-1];
  assign top_s    = acc_next[ACC_W-1];

  // Rollover events of this cycle's update, one rule set per mode.
  assign carry_evt = valid & ~is_signed & sum_w[ACC_W];
  assign pos_evt   = valid &  is_signed & ~top_a & ~top_b &  top_s;
  assign neg_evt   = valid &  is_signed &  top_a &  top_b & ~top_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      ovf_pulse <= 1'b0;
    end else if (clear) begin
      acc       <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= carry_evt | pos_evt | neg_evt;
      if (valid) acc <= acc_next;
    end
  end
endmodule

// File: rtl/mac_ext_counter.sv
module mac_ext_counter #(
  parameter int EXT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  mac_pkg::roll_dir_e    dir,
  output logic [EXT_W-1:0]      count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else begin
      case (dir)
        mac_pkg::ROLL_UP:   count <= count + 1'b1;
        mac_pkg::ROLL_DOWN: count <= count - 1'b1;
        default:            count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mac_top.sv
module mac_top #(
  parameter int OP_W  = 4,
  parameter int ACC_W = 2 * mac_pkg::native_width(OP_W),
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             valid,
  input  logic             is_signed,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_pulse,
  output logic [EXT_W-1:0] ext_cnt
);
  localparam int NW = mac_pkg::native_width(OP_W);

  logic [NW-1:0]      a_native, b_native;
  logic [ACC_W-1:0]   addend;
  logic               carry_evt, pos_evt, neg_evt;
  mac_pkg::roll_dir_e roll_dir;

  mac_operand_map #(.IN_W(OP_W), .OUT_W(NW)) u_map_a (
    .is_signed(is_signed), .raw(op_a), .mapped(a_native)
  );
  mac_operand_map #(.IN_W(OP_W), .OUT_W(NW)) u_map_b (
    .is_signed(is_signed), .raw(op_b), .mapped(b_native)
  );

  mac_multiplier #(.NW(NW), .ACC_W(ACC_W)) u_mul (
    .is_signed(is_signed), .a_n(a_native), .b_n(b_native), .addend(addend)
  );

  mac_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
    .is_signed(is_signed), .addend(addend), .acc(acc_out),
    .ovf_pulse(ovf_pulse), .carry_evt(carry_evt),
    .pos_evt(pos_evt), .neg_evt(neg_evt)
  );

  always_comb begin
    if (carry_evt || pos_evt) roll_dir = mac_pkg::ROLL_UP;
    else if (neg_evt)         roll_dir = mac_pkg::ROLL_DOWN;
    else                      roll_dir = mac_pkg::ROLL_NONE;
  end

  mac_ext_counter #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dir(roll_dir), .count(ext_cnt)
  );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int ACC_W = 18,
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             valid,
  input logic             is_signed,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_pulse,
  input logic [EXT_W-1:0] ext_cnt,
  input logic             carry_evt,
  input logic             pos_evt,
  input logic             neg_evt
);
  // R4: unsigned rollover pulse exactly when the value drops
  p_unsigned_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clear && !is_signed) |=> (ovf_pulse == (acc_out < $past(acc_out))));

  // R5 and R9: positive signed overflow lands negative and counts up
  p_signed_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && pos_evt) |=> (acc_out[ACC_W-1] && ovf_pulse &&
                             ext_cnt == EXT_W'($past(ext_cnt) + 1'b1)));

  // R9: negative signed overflow lands non-negative and counts down
  p_signed_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && neg_evt) |=> (!acc_out[ACC_W-1] && ovf_pulse &&
                             ext_cnt == EXT_W'($past(ext_cnt) - 1'b1)));

  // R7: idle cycles hold state and give no pulse
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !clear) |=> ($stable(acc_out) && $stable(ext_cnt) && !ovf_pulse));

  // R8 and R10: clear wins and zeroes everything
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_out == '0 && ext_cnt == '0 && !ovf_pulse));

  // R6: a pulse only follows an accepted update
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ($past(valid) && !$past(clear)));

  // R9: at most one rollover kind per update
  p_one_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({carry_evt, pos_evt, neg_evt}));
endmodule

bind mac_top mac_checker #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
  .is_signed(is_signed), .acc_out(acc_out), .ovf_pulse(ovf_pulse),
  .ext_cnt(ext_cnt), .carry_evt(carry_evt), .pos_evt(pos_evt),
  .neg_evt(neg_evt)
);

// File: tb/tb_mac_top.sv
module tb_mac_top;
  localparam int OP_W  = 4;
  localparam int ACC_W = 10;
  localparam int EXT_W = 6;
  localparam int AMOD  = 1 << ACC_W;
  localparam int EMOD  = 1 << EXT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clear = 1'b0;
  logic             valid = 1'b0;
  logic             is_signed = 1'b0;
  logic [OP_W-1:0]  op_a = '0;
  logic [OP_W-1:0]  op_b = '0;
  logic [ACC_W-1:0] acc_out;
  logic             ovf_pulse;
  logic [EXT_W-1:0] ext_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int m_acc = 0, m_ext = 0, m_ovf = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mac_top #(.OP_W(OP_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
    .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
    .acc_out(acc_out), .ovf_pulse(ovf_pulse), .ext_cnt(ext_cnt)
  );

  task automatic check(input int got, input int exp, input string req);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int as_signed4(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // Bench model from the requirements
  task automatic model(input bit v, input bit s, input bit c, input int a, input int b);
    int prod, add, sum, ta, tb_, ts;
    if (c) begin
      m_acc = 0; m_ext = 0; m_ovf = 0;
    end else if (v) begin
      prod = s ? as_signed4(a) * as_signed4(b) : a * b;
      add  = ((prod % AMOD) + AMOD) % AMOD;
      sum  = m_acc + add;
      ta = (m_acc >> (ACC_W-1)) & 1;
      tb_ = (add >> (ACC_W-1)) & 1;
      ts = ((sum % AMOD) >> (ACC_W-1)) & 1;
      m_ovf = 0;
      if (!s && sum >= AMOD) begin m_ovf = 1; m_ext = (m_ext + 1) % EMOD; end
      if (s && ta == 0 && tb_ == 0 && ts == 1) begin m_ovf = 1; m_ext = (m_ext + 1) % EMOD; end
      if (s && ta == 1 && tb_ == 1 && ts == 0) begin m_ovf = 1; m_ext = (m_ext + EMOD - 1) % EMOD; end
      m_acc = sum % AMOD;
    end else begin
      m_ovf = 0;
    end
  endtask

  task automatic step(input bit v, input bit s, input bit c, input int a, input int b,
                      input string tag_acc, input string tag_ovf);
    @(negedge clk);
    valid = v; is_signed = s; clear = c;
    op_a = OP_W'(a); op_b = OP_W'(b);
    @(posedge clk);
    #1;
    model(v, s, c, a, b);
    check(int'(acc_out), m_acc, tag_acc);
    check(int'(ovf_pulse), m_ovf, tag_ovf);
    check(int'(ext_cnt), m_ext, "R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(int'(acc_out), 0, "R8");
    check(int'(ovf_pulse), 0, "R8");
    check(int'(ext_cnt), 0, "R8");
    rst_n = 1'b1;

    // R3 / R6: 225 per step in 10 bits wraps on the fifth step (1125 -> 101)
    for (int i = 0; i < 5; i++) step(1, 0, 0, 15, 15, "R3", "R6");
    check(int'(acc_out), 101, "R3");
    step(0, 0, 0, 15, 15, "R7", "R6");   // pulse gone next cycle
    step(0, 1, 0, 9, 9, "R7", "R7");

    // R10: clear with valid high
    step(1, 0, 1, 15, 15, "R10", "R10");

    // R1 / R4: full unsigned sweep with idle gaps
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if (((a * 16 + b) % 7) == 6) step(0, 0, 0, a, b, "R7", "R7");
        step(1, 0, 0, a, b, "R1", "R4");
      end
    end
    step(1, 1, 1, 0, 0, "R8", "R8");

    // R5: 49 per step crosses +511 on the eleventh step, then -56 steps
    for (int i = 0; i < 11; i++) step(1, 1, 0, 7, 7, "R5", "R5");
    check(int'(ext_cnt), 1, "R9");
    for (int i = 0; i < 22; i++) step(1, 1, 0, 8, 7, "R5", "R5");

    // R2 / R5: full signed sweep with idle gaps
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if (((a * 16 + b) % 5) == 4) step(0, 1, 0, a, b, "R7", "R7");
        step(1, 1, 0, a, b, "R2", "R5");
      end
    end
    // R2: single check of -6 * 3 from zero gives 1024 - 18
    step(1, 0, 1, 0, 0, "R8", "R8");
    step(1, 1, 0, 10, 3, "R2", "R5");
    check(int'(acc_out), AMOD - 18, "R2");

    // mixed modes
    for (int i = 0; i < 40; i++) step(1, i[0], 0, (i * 5) % 16, (i * 3 + 7) % 16, "R3", "R6");
    step(0, 0, 1, 0, 0, "R8", "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule